// File: doc/BRIEF.md
# SPI Master Command-Word Transmit Queue

This block queues outgoing SPI master frames. Software writes a 32-bit push word whose upper half is a per-frame command and whose lower half is the 16-bit frame data. The command half holds a continuous-select flag, a three-bit attribute selector, an end-of-queue flag, a counter-clear flag and a six-bit chip-select pattern. Each accepted write places one merged word in a four-entry FIFO. A read of the push word returns the oldest queued word.

A shift engine takes words from the head with a start strobe and reports the end of each frame. The queue drives the chip-select lines from the command of the frame in flight. Between frames those lines are held or released according to that frame's continuous-select flag. An end-of-queue frame raises a one-cycle pulse when it finishes and then halts further pops until a restart strobe. While the module-enable input is low, writes have no effect.

Word layout: bit 31 continuous select, bits 30:28 attribute select, bit 27 end of queue, bit 26 counter clear, bits 25:22 reserved (always zero), bits 21:16 chip-select pattern, bits 15:0 data.

Top module: `spi_cmd_txq`

## Requirements
- R1: After reset `rd_data` is 0, `pop_valid`, `cs_act`, `eoq_pulse`, `halted` and `overflow` are all 0.
- R2: An enabled write whose strobes touch only bytes 0 and 1 pushes one word: the strobed bytes are taken from `wr_data`, and every other byte keeps the value from the previous accepted write (reset value 0).
- R3: An enabled write touching only bytes 2 and 3 pushes one word that carries the new command and the data of the previous write. A write touching all four bytes pushes exactly one word.
- R4: Bits 25:22 read as 0 in every queued word and in `rd_data`, whatever was written to them.
- R5: `rd_data` is the head word when `enable` is 1 and the queue is not empty. Otherwise it is the last word written while enabled.
- R6: While `enable` is 0, writes push nothing and do not change `rd_data`.
- R7: The queue holds 4 words. A write while full is dropped, and it sets `overflow`, which stays 1 until reset.
- R8: Words leave in write order. `pop_valid` is 1 only when the queue is not empty, no frame is in flight and the block is not halted. A `frame_start` while `pop_valid` is 0 is ignored.
- R9: From the cycle after a pop, `cs_act` equals bits 21:16 of the popped word. After `frame_end`, `cs_act` returns to 0 if bit 31 of that word was 0, and otherwise stays unchanged.
- R10: Held chip selects persist while the queue is empty. They are replaced by the pattern of the next popped word.
- R11: When a frame with bit 27 set ends, `eoq_pulse` is 1 for exactly the next cycle and `halted` becomes 1. `pop_valid` then stays 0 and pops are ignored until `restart` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; writes are ignored when 0 |
| wr_en | input | 1 | Push-word write strobe |
| wr_strb | input | 4 | Byte strobes of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read-back of the push word |
| frame_start | input | 1 | Shift engine takes the head word |
| frame_end | input | 1 | Shift engine finished the current frame |
| restart | input | 1 | Clears the halt after end of queue |
| pop_valid | output | 1 | A head word may be taken |
| frame_word | output | 32 | Head word offered to the shift engine |
| cs_act | output | 6 | Active-high chip-select lines |
| eoq_pulse | output | 1 | One-cycle end-of-queue pulse |
| halted | output | 1 | Pops stopped after end of queue |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with its default depth of 4. With that depth, five writes in a row are enough to fill the queue and reach the dropped-write and sticky-overflow path. Partial-strobe writes, a write while disabled, a continuous-select frame followed by an empty queue, and an end-of-queue halt with restart all fit in one short run. Popped words are compared against a scoreboard queue filled by the write driver.

// File: rtl/spi_cmd_txq.sv
module spi_cmd_txq #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        wr_en,
  input  logic [3:0]  wr_strb,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        frame_start,
  input  logic        frame_end,
  input  logic        restart,
  output logic        pop_valid,
  output logic [31:0] frame_word,
  output logic [5:0]  cs_act,
  output logic        eoq_pulse,
  output logic        halted,
  output logic        overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [31:0] RSV_MASK = 32'h03C0_0000;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [31:0]   stage, merged;
  logic          busy, cur_cont, cur_eoq;

  always_comb begin
    for (int b = 0; b < 4; b++)
      merged[8*b +: 8] = wr_strb[b] ? wr_data[8*b +: 8] : stage[8*b +: 8];
    merged = merged & ~RSV_MASK;
  end

  wire empty   = (cnt == '0);
  wire full    = (cnt == CW'(DEPTH));
  wire wr_ok   = enable && wr_en && (|wr_strb);
  wire do_push = wr_ok && !full;
  wire do_pop  = frame_start && pop_valid;

  assign pop_valid  = !empty && !halted && !busy;
  assign frame_word = mem[rp];
  assign rd_data    = (enable && !empty) ? mem[rp] : stage;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      stage <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) stage <= merged;
      if (wr_ok && full) overflow <= 1'b1;
      if (do_push) begin
        mem[wp] <= merged;
        wp <= nxt(wp);
      end
      if (do_pop) rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur_cont <= 1'b0;
      cur_eoq <= 1'b0;
      cs_act <= '0;
      eoq_pulse <= 1'b0;
      halted <= 1'b0;
    end else begin
      eoq_pulse <= 1'b0;
      if (restart) halted <= 1'b0;
      if (do_pop) begin
        busy <= 1'b1;
        cur_cont <= frame_word[31];
        cur_eoq <= frame_word[27];
        cs_act <= frame_word[21:16];
      end else if (frame_end && busy) begin
        busy <= 1'b0;
        if (!cur_cont) cs_act <= '0;
        if (cur_eoq) begin
          eoq_pulse <= 1'b1;
          halted <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_txq_chk.sv
module spi_cmd_txq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic [31:0] rd_data,
  input logic        frame_start,
  input logic        pop_valid,
  input logic [31:0] frame_word,
  input logic [5:0]  cs_act,
  input logic        eoq_pulse,
  input logic        halted,
  input logic        overflow
);
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R11
  eoq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoq_pulse |=> !eoq_pulse);
  // R11
  halt_blocks_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !pop_valid);
  // R9
  cs_follows_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pop_valid) |=> (cs_act == $past(frame_word[21:16])));
  // R6
  disabled_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (enable || $stable(rd_data)));
  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[25:22] == 4'b0);
endmodule

bind spi_cmd_txq spi_cmd_txq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rd_data(rd_data),
  .frame_start(frame_start), .pop_valid(pop_valid), .frame_word(frame_word),
  .cs_act(cs_act), .eoq_pulse(eoq_pulse), .halted(halted), .overflow(overflow)
);

// File: tb/sim_spi_cmd_txq.sv
module sim_spi_cmd_txq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, wr_en = 1'b0, frame_start = 1'b0, frame_end = 1'b0, restart = 1'b0;
  logic [3:0] wr_strb = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, frame_word;
  logic [5:0] cs_act;
  logic pop_valid, eoq_pulse, halted, overflow;

  int n_chk = 0, n_bad = 0;
  bit [31:0] sb[$];
  bit [31:0] model_stage = '0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_cmd_txq u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] mrg(bit [31:0] s, bit [3:0] st, bit [31:0] d);
    for (int b = 0; b < 4; b++) if (st[b]) s[8*b +: 8] = d[8*b +: 8];
    return s & ~32'h03C0_0000;
  endfunction

  task automatic push(bit [3:0] st, bit [31:0] d, bit expect_keep);
    @(negedge clk);
    wr_en = 1; wr_strb = st; wr_data = d;
    if (enable) begin
      model_stage = mrg(model_stage, st, d);
      if (expect_keep) sb.push_back(model_stage);
    end
    @(negedge clk);
    wr_en = 0; wr_strb = '0;
  endtask

  task automatic pop_cmp(string req);
    bit [31:0] e;
    e = sb.pop_front();
    chk({req, " pop_valid"}, {31'b0, pop_valid}, 32'd1);
    chk({req, " frame_word"}, frame_word, e);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    chk("R9 cs on pop", {26'b0, cs_act}, {26'b0, e[21:16]});
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
    chk("R9 cs after end", {26'b0, cs_act}, e[31] ? {26'b0, e[21:16]} : 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 rd_data", rd_data, 0);
    chk("R1 flags", {26'b0, pop_valid, eoq_pulse, halted, overflow, 2'b0}, 0);
    chk("R1 cs", {26'b0, cs_act}, 0);
    enable = 1;
    // R3 full write, R4 reserved bits written as ones
    push(4'hF, 32'h73C5_1234, 1);
    chk("R3 one entry rd_data", rd_data, 32'h7005_1234);
    chk("R4 reserved", rd_data & 32'h03C0_0000, 0);
    // R2 data-half writes
    push(4'h3, 32'h0000_ABCD, 1);
    push(4'h1, 32'h0000_00EE, 1);
    // R3 command-half write: continuous, pattern 100000
    push(4'hC, 32'h8020_0000, 1);
    chk("R5 head", rd_data, 32'h7005_1234);
    // R7 push when full
    push(4'hF, 32'h1111_2222, 0);
    chk("R7 overflow", {31'b0, overflow}, 1);
    chk("R7 head kept", rd_data, 32'h7005_1234);
    // R6 disabled
    enable = 0;
    @(negedge clk);
    chk("R5 disabled readback", rd_data, model_stage);
    push(4'hF, 32'hFFFF_FFFF, 0);
    chk("R6 ignored", rd_data, model_stage);
    enable = 1;
    @(negedge clk);
    // R8 order, R2/R3 contents, R9 chip selects
    pop_cmp("R3 word1");
    pop_cmp("R2 word2");
    pop_cmp("R2 word3");
    pop_cmp("R10 word4");
    chk("R7 overflow still", {31'b0, overflow}, 1);
    // R8 pop when empty ignored; R10 cs held
    chk("R8 empty", {31'b0, pop_valid}, 0);
    frame_start = 1; @(negedge clk); frame_start = 0; @(negedge clk);
    chk("R10 held while empty", {26'b0, cs_act}, 32'h20);
    // R11 end of queue word, new pattern replaces held one (R10)
    push(4'hF, 32'h0803_5555, 1);
    chk("R10 held before pop", {26'b0, cs_act}, 32'h20);
    begin
      bit [31:0] e;
      e = sb.pop_front();
      chk("R8 eoq word", frame_word, e);
      frame_start = 1; @(negedge clk); frame_start = 0;
      chk("R10 replaced", {26'b0, cs_act}, 32'h03);
      frame_end = 1; @(negedge clk); frame_end = 0;
      chk("R11 pulse", {31'b0, eoq_pulse}, 1);
      chk("R11 halted", {31'b0, halted}, 1);
      chk("R9 released", {26'b0, cs_act}, 0);
      @(negedge clk);
      chk("R11 pulse one cycle", {31'b0, eoq_pulse}, 0);
    end
    push(4'hF, 32'h0001_7777, 1);
    chk("R11 no pop while halted", {31'b0, pop_valid}, 0);
    frame_start = 1; @(negedge clk); frame_start = 0; @(negedge clk);
    chk("R11 pop ignored", rd_data, 32'h0001_7777);
    chk("R11 cs unchanged", {26'b0, cs_act}, 0);
    restart = 1; @(negedge clk); restart = 0;
    chk("R11 restart", {31'b0, halted}, 0);
    pop_cmp("R11 after restart");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule